// File: doc/BRIEF.md
# Double-Buffered PWM Time-Base with Selectable Period Load Event

This block is the time-base of one PWM channel. A counter runs up from zero to the active period, then back down to zero, and repeats. The period value is held twice. Software writes a staging (shadow) copy, and the copy the counter uses (the active copy) takes the staged value only at a chosen load event. That event can be counter-at-zero, a synchronisation event, or either one. A bypass mode lets writes reach the active copy at once. A fractional extension field travels in the same word as the whole-count period and obeys the same rules, so it is available to a later fine-edge stage.

A sync event is either a pulse on the external sync input or a software-forced sync. In one-shot mode a forced sync only gets through when an arm bit has been set beforehand, and passing through uses up the arm. A forced sync that passes is also driven out on the sync output, so downstream channels can follow it. A follower channel can reload its counter from a phase register on every sync event. A sticky flag records each external sync and is cleared by writing 1 to it. Software reaches all state through a single-cycle register write port and a combinational read port.

Top module: `pwmtb_period_loader`

## Requirements
- R1: With bypass off (CTRL bit 0 = 0), a write to the PERIOD address stores the value in the shadow copy and a read of that address returns the shadow. `period_active` changes only on the clock edge that ends a cycle in which a load event is selected and occurs, and it then takes the shadow value held at the start of that cycle.
- R2: With bypass on (CTRL bit 0 = 1), a write to PERIOD updates `period_active` on that write's clock edge, a read of PERIOD returns the active copy, and load events are ignored.
- R3: The load select in CTRL bits 2:1 works as follows: 0 loads at zero only, 1 loads at zero or sync, 2 loads at sync only, and 3 behaves like 0. A zero event is a cycle in which the counter is 0 while running (CTRL bit 5 = 1).
- R4: With load select 2, the active period never changes without a sync event, whatever is written to PERIOD. A sync event is a cycle with `sync_in` high, or the cycle after a software sync passes the gate.
- R5: The fractional field (PERIOD bits 23:16) moves with the whole-count field (bits 15:0) under every rule above. In one-shot mode, a later software sync that finds the gate disarmed loads neither field.
- R6: A write to SYNC with bit 1 set forces a software sync. If CTRL bit 4 (one-shot) is 0, the sync always passes. If CTRL bit 4 is 1, it passes only when the arm flag is set, and passing clears that flag. The arm flag is set by writing SYNC with bit 0 set, reads back as SYNC bit 0, and the set wins if it coincides with a pass. A passed sync drives `sync_out` high for exactly the next cycle.
- R7: Every cycle with `sync_in` high sets STATUS bit 0. Writing STATUS with bit 0 = 1 clears it, unless `sync_in` is high in the same cycle. Writing 0 has no effect.
- R8: With CTRL bit 3 (phase enable) set and the counter running, a sync event loads the counter from the PHASE register on the next edge and sets the direction to up.
- R9: While running, the counter steps up by one until it is at or above the active whole period, then turns down. On reaching 0 it turns up again, giving 0,1..P,P-1..1,0. When not running, it holds its value. The direction is reported on `count_down` and in COUNT bit 16.
- R10: When a zero event and a sync event occur in the same cycle, exactly one shadow-to-active transfer happens. A PERIOD write in that same cycle lands in the shadow and takes effect at the following qualifying event.
- R11: The register map is as follows. Address 0 is CTRL, with bits [5:0] = run, one-shot, phase enable, load select (2 bits), bypass, from most significant to least significant. Address 1 is PERIOD. Address 2 is PHASE, 16 bits. Address 3 is STATUS. Address 4 is SYNC. Address 5 is COUNT, read-only, with the direction in bit 16 above the counter. All other addresses read 0. Every register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 3 | Register address for write and read |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for `addr`, combinational |
| sync_in | input | 1 | External sync pulse |
| sync_out | output | 1 | One-cycle pulse for each software sync that passes the gate |
| count | output | 16 | Time-base counter value |
| count_down | output | 1 | Counter direction, 1 = counting down |
| period_active | output | 24 | Active period: fraction in bits 23:16, whole count in bits 15:0 |

## Verification
The load rules are exercised under each select value. Period writes placed in the middle of a count cycle show that the active value waits for counter-zero. Writes followed by long sync-free stretches in sync-only mode show that no spurious transfer happens. One-shot tests apply forced syncs with the gate disarmed, armed, and disarmed again; this separates a gate that is honoured from one that reloads the fractional field on every sync. A write aligned with a cycle where zero and external sync coincide tells a single transfer apart from a double one, and the reserved select value is driven with a sync in mid-cycle to show that it ignores sync. A cycle-accurate behavioural model runs alongside and compares the counter, direction, active period, sync output and read data on every cycle.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

    localparam int CNT_W  = 16;
    localparam int FRAC_W = 8;
    localparam int ADDR_W = 3;
    localparam int PRD_W  = CNT_W + FRAC_W;
    localparam int DATA_W = PRD_W;

    typedef enum logic [1:0] {
        LDS_ZERO      = 2'd0,
        LDS_ZERO_SYNC = 2'd1,
        LDS_SYNC      = 2'd2,
        LDS_RSVD      = 2'd3
    } load_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_PERIOD = 3'd1,
        RA_PHASE  = 3'd2,
        RA_STATUS = 3'd3,
        RA_SYNC   = 3'd4,
        RA_COUNT  = 3'd5
    } reg_addr_e;

    // Control word, bypass in bit 0
    typedef struct packed {
        logic      run;
        logic      oneshot;
        logic      phase_en;
        load_sel_e lsel;
        logic      bypass;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic logic loads_at_zero(load_sel_e s);
        return s != LDS_SYNC;
    endfunction

    function automatic logic loads_at_sync(load_sel_e s);
        return (s == LDS_ZERO_SYNC) || (s == LDS_SYNC);
    endfunction

endpackage

// File: rtl/pwmtb_period_buf.sv
module pwmtb_period_buf #(
    parameter int CNT_W  = pwmtb_pkg::CNT_W,
    parameter int FRAC_W = pwmtb_pkg::FRAC_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bypass,
    input  logic                      wr,
    input  logic [CNT_W+FRAC_W-1:0]   wdata,
    input  logic                      xfer,
    output logic [CNT_W+FRAC_W-1:0]   act_o,
    output logic [CNT_W+FRAC_W-1:0]   shd_o
);
    localparam int PW = CNT_W + FRAC_W;

    logic [PW-1:0] act_q, shd_q;

    // Whole and fractional lanes share the same load decision
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            shd_q <= '0;
        end else begin
            if (bypass && wr)
                act_q <= wdata;
            else if (xfer)
                act_q <= shd_q;
            if (!bypass && wr)
                shd_q <= wdata;
        end
    end

    assign act_o = act_q;
    assign shd_o = shd_q;

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter #(
    parameter int CNT_W = pwmtb_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] prd,
    input  logic             sync_load,
    input  logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             down_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (run) begin
            if (sync_load) begin
                cnt_q  <= phase;
                down_q <= 1'b0;
            end else if (!down_q) begin
                if (cnt_q >= prd) begin
                    down_q <= 1'b1;
                    cnt_q  <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                if (cnt_q == '0) begin
                    down_q <= 1'b0;
                    cnt_q  <= (prd == '0) ? '0 : CNT_W'(1);
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    assign cnt_o  = cnt_q;
    assign down_o = down_q;

endmodule

// File: rtl/pwmtb_ctrl_regs.sv
module pwmtb_ctrl_regs
    import pwmtb_pkg::*;
#(
    parameter int CNT_W  = pwmtb_pkg::CNT_W,
    parameter int ADDR_W = pwmtb_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              sync_in,
    output ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]  phase_o,
    output logic              flag_o,
    output logic              armed_o,
    output logic              sw_sync_o
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] phase_q;
    logic             flag_q, armed_q, sw_q;
    logic             wr_ctrl, wr_phase, wr_stat, wr_sync, sw_pass;

    assign wr_ctrl  = wr_en && (addr == RA_CTRL);
    assign wr_phase = wr_en && (addr == RA_PHASE);
    assign wr_stat  = wr_en && (addr == RA_STATUS);
    assign wr_sync  = wr_en && (addr == RA_SYNC);

    // Software sync gate
    assign sw_pass = wr_sync && wdata[1] && (!ctrl_q.oneshot || armed_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            phase_q <= '0;
            flag_q  <= 1'b0;
            armed_q <= 1'b0;
            sw_q    <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            if (wr_phase)
                phase_q <= wdata;
            if (sync_in)
                flag_q <= 1'b1;
            else if (wr_stat && wdata[0])
                flag_q <= 1'b0;
            if (wr_sync && wdata[0])
                armed_q <= 1'b1;
            else if (sw_pass && ctrl_q.oneshot)
                armed_q <= 1'b0;
            sw_q <= sw_pass;
        end
    end

    assign ctrl_o    = ctrl_q;
    assign phase_o   = phase_q;
    assign flag_o    = flag_q;
    assign armed_o   = armed_q;
    assign sw_sync_o = sw_q;

endmodule

// File: rtl/pwmtb_period_loader.sv
module pwmtb_period_loader
    import pwmtb_pkg::*;
#(
    parameter int CNT_W  = pwmtb_pkg::CNT_W,
    parameter int FRAC_W = pwmtb_pkg::FRAC_W,
    parameter int ADDR_W = pwmtb_pkg::ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [CNT_W+FRAC_W-1:0] wdata,
    output logic [CNT_W+FRAC_W-1:0] rdata,
    input  logic                    sync_in,
    output logic                    sync_out,
    output logic [CNT_W-1:0]        count,
    output logic                    count_down,
    output logic [CNT_W+FRAC_W-1:0] period_active
);
    localparam int DW = CNT_W + FRAC_W;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] phase_q, cnt_q;
    logic             flag_q, armed_q, sw_sync_q, cnt_down_q;
    logic [DW-1:0]    prd_act, prd_shd;

    logic       cfg_bypass, cfg_run, cfg_oneshot, cfg_phase_en;
    logic [1:0] cfg_lsel;
    logic       zero_evt, sync_evt, xfer, prd_wr;

    pwmtb_ctrl_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata[CNT_W-1:0]),
        .sync_in   (sync_in),
        .ctrl_o    (ctrl_q),
        .phase_o   (phase_q),
        .flag_o    (flag_q),
        .armed_o   (armed_q),
        .sw_sync_o (sw_sync_q)
    );

    assign cfg_bypass   = ctrl_q.bypass;
    assign cfg_run      = ctrl_q.run;
    assign cfg_oneshot  = ctrl_q.oneshot;
    assign cfg_phase_en = ctrl_q.phase_en;
    assign cfg_lsel     = ctrl_q.lsel;

    assign zero_evt = cfg_run && (cnt_q == '0);
    assign sync_evt = sync_in || sw_sync_q;
    // One transfer at most, however many qualifying events coincide
    assign xfer = !cfg_bypass &&
                  ((loads_at_zero(ctrl_q.lsel) && zero_evt) ||
                   (loads_at_sync(ctrl_q.lsel) && sync_evt));
    assign prd_wr = wr_en && (addr == RA_PERIOD);

    pwmtb_period_buf #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_prd (
        .clk    (clk),
        .rst    (rst),
        .bypass (cfg_bypass),
        .wr     (prd_wr),
        .wdata  (wdata),
        .xfer   (xfer),
        .act_o  (prd_act),
        .shd_o  (prd_shd)
    );

    pwmtb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (cfg_run),
        .prd       (prd_act[CNT_W-1:0]),
        .sync_load (sync_evt && cfg_phase_en),
        .phase     (phase_q),
        .cnt_o     (cnt_q),
        .down_o    (cnt_down_q)
    );

    always_comb begin
        case (addr)
            RA_CTRL:   rdata = DW'(ctrl_q);
            RA_PERIOD: rdata = cfg_bypass ? prd_act : prd_shd;
            RA_PHASE:  rdata = DW'(phase_q);
            RA_STATUS: rdata = DW'(flag_q);
            RA_SYNC:   rdata = DW'(armed_q);
            RA_COUNT:  rdata = DW'({cnt_down_q, cnt_q});
            default:   rdata = '0;
        endcase
    end

    assign sync_out      = sw_sync_q;
    assign count         = cnt_q;
    assign count_down    = cnt_down_q;
    assign period_active = prd_act;

endmodule

// File: rtl/pwmtb_checker.sv
module pwmtb_checker #(
    parameter int CNT_W = pwmtb_pkg::CNT_W,
    parameter int PW    = pwmtb_pkg::PRD_W
) (
    input logic             clk,
    input logic             rst,
    input logic             bypass,
    input logic [1:0]       lsel,
    input logic             zero_evt,
    input logic             sync_evt,
    input logic             sync_in,
    input logic             flag,
    input logic             oneshot,
    input logic             armed,
    input logic             sync_out,
    input logic             run,
    input logic             phase_en,
    input logic [PW-1:0]    prd_active,
    input logic [CNT_W-1:0] count
);

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bypass && !(lsel != 2'd2 && zero_evt) &&
         !((lsel == 2'd1 || lsel == 2'd2) && sync_evt)) |=> $stable(prd_active)); // R1

    AST_SYNC_ONLY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!bypass && lsel == 2'd2 && !sync_evt) |=> $stable(prd_active)); // R4

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> flag); // R7

    AST_ONESHOT_GATE: assert property (@(posedge clk) disable iff (rst)
        ($past(oneshot) && sync_out) |-> $past(armed)); // R6

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(run) && !$past(sync_evt && phase_en)) |->
        (count == $past(count) + 1'b1 || count + 1'b1 == $past(count) ||
         (count == '0 && $past(count) == '0))); // R9

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(run)) |-> $stable(count)); // R9

endmodule

bind pwmtb_period_loader pwmtb_checker chk_i (
    .clk        (clk),
    .rst        (rst),
    .bypass     (cfg_bypass),
    .lsel       (cfg_lsel),
    .zero_evt   (zero_evt),
    .sync_evt   (sync_evt),
    .sync_in    (sync_in),
    .flag       (flag_q),
    .oneshot    (cfg_oneshot),
    .armed      (armed_q),
    .sync_out   (sync_out),
    .run        (cfg_run),
    .phase_en   (cfg_phase_en),
    .prd_active (period_active),
    .count      (count)
);

// File: tb/pwmtb_period_loader_tb.sv
module pwmtb_period_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [23:0] wdata = '0;
    logic [23:0] rdata;
    logic        sync_in = 1'b0;
    logic        sync_out;
    logic [15:0] count;
    logic        count_down;
    logic [23:0] period_active;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwmtb_period_loader dut_i (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .addr          (addr),
        .wdata         (wdata),
        .rdata         (rdata),
        .sync_in       (sync_in),
        .sync_out      (sync_out),
        .count         (count),
        .count_down    (count_down),
        .period_active (period_active)
    );

    // Behavioural reference model, updated on every rising edge
    int m_cnt, m_down, m_act, m_shd, m_ctrl, m_phase, m_flag, m_armed, m_swq;
    bit m_live = 1'b0;

    always @(posedge clk) begin : ref_model
        int bp, ls, pe, os, run, zero, sev, xfer, pass, wa, prd;
        if (rst) begin
            m_cnt = 0; m_down = 0; m_act = 0; m_shd = 0; m_ctrl = 0;
            m_phase = 0; m_flag = 0; m_armed = 0; m_swq = 0;
            m_live = 1'b1;
        end else begin
            bp  = m_ctrl & 1;
            ls  = (m_ctrl >> 1) & 3;
            pe  = (m_ctrl >> 3) & 1;
            os  = (m_ctrl >> 4) & 1;
            run = (m_ctrl >> 5) & 1;
            wa  = wr_en ? int'(addr) : -1;
            prd = m_act & 16'hFFFF;
            zero = (run != 0) && (m_cnt == 0);
            sev  = (sync_in || m_swq != 0) ? 1 : 0;
            xfer = (bp == 0) && (((ls != 2) && zero) || ((ls == 1 || ls == 2) && sev != 0));
            pass = (wa == 4) && wdata[1] && (os == 0 || m_armed != 0);
            if (run != 0) begin
                if (sev != 0 && pe != 0) begin
                    m_cnt = m_phase; m_down = 0;
                end else if (m_down == 0) begin
                    if (m_cnt >= prd) begin
                        m_down = 1;
                        m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                    end else m_cnt = m_cnt + 1;
                end else begin
                    if (m_cnt == 0) begin
                        m_down = 0;
                        m_cnt = (prd == 0) ? 0 : 1;
                    end else m_cnt = m_cnt - 1;
                end
            end
            if (bp != 0 && wa == 1) m_act = int'(wdata);
            else if (xfer) m_act = m_shd;
            if (bp == 0 && wa == 1) m_shd = int'(wdata);
            if (wa == 0) m_ctrl = int'(wdata) & 63;
            if (wa == 2) m_phase = int'(wdata) & 16'hFFFF;
            if (sync_in) m_flag = 1;
            else if (wa == 3 && wdata[0]) m_flag = 0;
            if (wa == 4 && wdata[0]) m_armed = 1;
            else if (pass && os != 0) m_armed = 0;
            m_swq = pass ? 1 : 0;
        end
    end

    function automatic int exp_rdata(input int a);
        case (a)
            0: return m_ctrl;
            1: return ((m_ctrl & 1) != 0) ? m_act : m_shd;
            2: return m_phase;
            3: return m_flag;
            4: return m_armed;
            5: return (m_down << 16) | m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic cmp(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (m_live && !done) begin
            cmp("R9 count", int'(count), m_cnt);
            cmp("R9 direction", int'(count_down), m_down);
            cmp("R1 period_active", int'(period_active), m_act);
            cmp("R6 sync_out", int'(sync_out), m_swq);
            cmp("R11 rdata", int'(rdata), exp_rdata(int'(addr)));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; addr = 3'(a); wdata = 24'(d);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        int guard = 0;
        while (int'(count) != v && guard < 300) begin
            tick(1);
            guard++;
        end
    endtask

    task automatic rd_check(input string tag, input int a, input int exp);
        addr = 3'(a);
        @(negedge clk);
        cmp(tag, int'(rdata), exp);
    endtask

    task automatic out_check(input string tag, input int act_sel, input int exp);
        @(negedge clk);
        case (act_sel)
            0: cmp(tag, int'(period_active), exp);
            1: cmp(tag, int'(count), exp);
            2: cmp(tag, int'(sync_out), exp);
            default: cmp(tag, int'(count_down), exp);
        endcase
    endtask

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        tick(3);
        rst = 1'b0;
        // Reset state (R11)
        out_check("R11 reset count", 1, 0);
        out_check("R11 reset period", 0, 0);
        rd_check("R11 reset ctrl", 0, 0);

        // Shadow mode, load at zero (R1, R3)
        wr(1, 24'h03000A);
        out_check("R1 active untouched by shadow write", 0, 0);
        rd_check("R1 read returns shadow", 1, 24'h03000A);
        wr(0, 24'h20);
        tick(1);
        out_check("R3 mode 0 loads at zero", 0, 24'h03000A);
        tick(3);
        wr(1, 24'h010006);
        out_check("R1 mid-cycle write held", 0, 24'h03000A);
        tick(25);
        out_check("R5 fraction loaded with whole at zero", 0, 24'h010006);

        // Bypass (R2)
        wr(0, 24'h21);
        wr(1, 24'h00000C);
        out_check("R2 bypass write immediate", 0, 24'h00000C);
        rd_check("R2 bypass read active", 1, 24'h00000C);

        // Sync-only, non one-shot (R4, R6)
        wr(0, 24'h24);
        wr(1, 24'h050008);
        tick(60);
        out_check("R4 no sync keeps period", 0, 24'h00000C);
        wr(4, 24'h2);
        out_check("R6 free sync drives sync_out", 2, 1);
        tick(1);
        out_check("R4 sync loads period", 0, 24'h050008);

        // One-shot gate (R5, R6)
        wr(0, 24'h34);
        wr(1, 24'h07000A);
        wr(4, 24'h2);
        out_check("R6 disarmed force blocked", 2, 0);
        tick(3);
        out_check("R6 disarmed force no load", 0, 24'h050008);
        wr(4, 24'h1);
        rd_check("R6 arm reads back", 4, 1);
        wr(4, 24'h2);
        out_check("R6 armed force passes", 2, 1);
        tick(1);
        out_check("R6 armed force loads", 0, 24'h07000A);
        rd_check("R6 arm consumed", 4, 0);
        wr(1, 24'h090004);
        wr(4, 24'h2);
        tick(5);
        out_check("R5 fraction not reloaded without arm", 0, 24'h07000A);

        // Status flag (R7)
        sync_in = 1'b1; tick(1); sync_in = 1'b0;
        rd_check("R7 flag set by sync_in", 3, 1);
        wr(3, 24'h0);
        rd_check("R7 write 0 keeps flag", 3, 1);
        wr(3, 24'h1);
        rd_check("R7 write 1 clears", 3, 0);
        sync_in = 1'b1;
        wr(3, 24'h1);
        sync_in = 1'b0;
        rd_check("R7 set wins over clear", 3, 1);

        // Phase load (R8)
        wr(2, 24'h3);
        wr(0, 24'h28);
        tick(7);
        sync_in = 1'b1; tick(1); sync_in = 1'b0;
        out_check("R8 phase loaded on sync", 1, 3);
        out_check("R8 direction up after phase", 3, 0);

        // Coincident zero and sync (R10)
        wr(0, 24'h22);
        wr(1, 24'h020005);
        tick(15);
        wait_cnt(2);
        wr(1, 24'h030007);
        wait_cnt(0);
        sync_in = 1'b1;
        wr(1, 24'h040009);
        sync_in = 1'b0;
        out_check("R10 single transfer", 0, 24'h030007);
        rd_check("R10 same-cycle write in shadow", 1, 24'h040009);
        tick(20);
        out_check("R10 write taken at next event", 0, 24'h040009);

        // Reserved select ignores sync (R3) and counting shape (R9)
        wr(0, 24'h26);
        wait_cnt(2);
        wr(1, 24'h0A0009);
        sync_in = 1'b1; tick(1); sync_in = 1'b0;
        out_check("R3 reserved select ignores sync", 0, 24'h040009);
        tick(25);
        out_check("R3 reserved select loads at zero", 0, 24'h0A0009);
        wait_cnt(9);
        out_check("R9 up at peak", 3, 0);
        tick(1);
        out_check("R9 turns down after peak", 1, 8);
        out_check("R9 down flag", 3, 1);
        wr(0, 24'h0);
        tick(4);
        out_check("R9 halted counter holds", 1, int'(count));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule